// File: doc/BRIEF.md
# Compressed-to-native instruction expander

This unit sits between instruction fetch and a 32-bit native decoder. When the core runs in native state, it forwards each fetched 32-bit word unchanged. When the core runs in compressed state, it uses address bit 1 to pick one 16-bit halfword from the 32-bit fetch bus. It then rewrites that halfword into an equivalent 32-bit native instruction whose condition field is always-execute.

The supported compressed forms are the following:

- move, compare, add and subtract with an 8-bit immediate;
- register branch-exchange;
- the two-halfword long branch-with-link.

The long branch is stateful. The first half is held inside the block, and the native branch is only produced when the second half arrives. Any other halfword, and any out-of-sequence half, is reported as undefined.

Results are registered, so there is one cycle of latency. A flush input discards both the pending long-branch half and the output in flight.

Top module: `cx_expander`

## Requirements
- R1: In native state (`comp_state`=0), an accepted fetch word appears unchanged on `out_word`, with `out_valid`=1 and `out_undef`=0.
- R2: In compressed state, `addr_a1`=0 selects bits [15:0] of `fetch_word` and `addr_a1`=1 selects bits [31:16].
- R3: Every expanded instruction carries condition code 4'hE in `out_word[31:28]`.
- R4: A halfword with [15:13]=3'b001 is an immediate operation. Its fields are op=[12:11] (0 move, 1 compare, 2 add, 3 subtract), r=[10:8] and imm=[7:0]. The output is {4'hE, 8'h3B, 4'h0, {0,r}, 4'h0, imm} for move, {4'hE, 8'h35, {0,r}, 4'h0, 4'h0, imm} for compare, {4'hE, 8'h29, {0,r}, {0,r}, 4'h0, imm} for add and {4'hE, 8'h25, {0,r}, {0,r}, 4'h0, imm} for subtract.
- R5: In immediate expansions, bit 3 of every register field is 0, and the 8-bit immediate is zero-extended into the 12-bit field.
- R6: A halfword with [15:7]=9'b010001110 and [2:0]=0 is a branch-exchange on register s=[6:3] and expands to 32'hE12FFF10 | s. The target state is later taken from bit 0 of that register: 0 means native and 1 means compressed.
- R7: A halfword with [15:12]=4'hF and bit 11 = 0 (first half) stores bits [10:0] and produces no output (`out_valid`=0).
- R8: A halfword with [15:12]=4'hF and bit 11 = 1 (second half), when it directly follows a stored first half, emits {4'hE, 4'hB, off}. Here off is the 24-bit sign extension of {stored[10:0], current[10:0]}.
- R9: A second half with no first half pending yields `out_valid`=1, `out_undef`=1 and `out_word`=0. Any accepted input other than a first half clears the pending half.
- R10: Any other compressed halfword, including a branch-exchange with nonzero [2:0], yields `out_valid`=1, `out_undef`=1 and `out_word`=0.
- R11: While `flush`=1, the input is ignored, the next cycle shows `out_valid`=0, and any pending first half is discarded.
- R12: After reset, `out_valid`=0, `out_undef`=0 and no first half is pending.
- R13: An input accepted at one clock edge is visible at the outputs right after that edge, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Fetch word is present this cycle |
| fetch_word | input | 32 | Fetched 32-bit word |
| addr_a1 | input | 1 | Address bit 1 of the fetch, selects the halfword |
| comp_state | input | 1 | 1 = compressed state, 0 = native state |
| flush | input | 1 | Drop the in-flight output and the pending first half |
| out_word | output | 32 | Native instruction for the decoder |
| out_valid | output | 1 | `out_word` holds a result |
| out_undef | output | 1 | The result is an undefined instruction |

## Verification
The bench places one halfword in the upper half and different content in the lower half. A design that ignored or inverted `addr_a1` would then decode the wrong half and, for the chosen patterns, report undefined.

Long-branch pairs are sent with both a positive and a negative offset. This catches a missing or misplaced sign extension, or halves joined in the wrong order.

Two sequences target the pending state:
- an orphan second half, which a design that never cleared its pending flag would wrongly accept as a branch;
- a flush between the two halves, which must turn the second half into an undefined result.

Native words that resemble compressed encodings confirm that native state does no rewriting.

// File: rtl/cx_expander.sv
module cx_expander #(
  parameter int WORD_W = 32,
  parameter int OFF_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              addr_a1,
  input  logic              comp_state,
  input  logic              flush,
  output logic [WORD_W-1:0] out_word,
  output logic              out_valid,
  output logic              out_undef
);
  localparam int HALF_W = WORD_W / 2;
  localparam int BR_W   = 2 * OFF_W;
  localparam int IMM_W  = 24;
  localparam logic [3:0] COND_AL = 4'hE;

  logic [HALF_W-1:0] hw;
  logic              is_imm, is_bx, is_bl, bl_second;
  logic [3:0]        rreg;
  logic [7:0]        imm_op;
  logic [WORD_W-1:0] imm_word, bx_word, bl_word;
  logic [BR_W-1:0]   br_off;

  logic              pend_q, pend_d;
  logic [OFF_W-1:0]  hi_q, hi_d;
  logic [WORD_W-1:0] word_d;
  logic              valid_d, undef_d;

  assign hw        = addr_a1 ? fetch_word[WORD_W-1:HALF_W] : fetch_word[HALF_W-1:0];
  assign is_imm    = hw[15:13] == 3'b001;
  assign is_bx     = hw[15:7] == 9'b010001110 && hw[2:0] == 3'b000;
  assign is_bl     = hw[15:12] == 4'hF;
  assign bl_second = hw[11];
  assign rreg      = {1'b0, hw[10:8]};

  always_comb begin
    unique case (hw[12:11])
      2'd0: imm_op = 8'h3B;
      2'd1: imm_op = 8'h35;
      2'd2: imm_op = 8'h29;
      default: imm_op = 8'h25;
    endcase
    unique case (hw[12:11])
      2'd0: imm_word = {COND_AL, imm_op, 4'h0, rreg, 4'h0, hw[7:0]};
      2'd1: imm_word = {COND_AL, imm_op, rreg, 4'h0, 4'h0, hw[7:0]};
      default: imm_word = {COND_AL, imm_op, rreg, rreg, 4'h0, hw[7:0]};
    endcase
  end

  assign bx_word = {COND_AL, 24'h12FFF1, hw[6:3]};
  assign br_off  = {hi_q, hw[OFF_W-1:0]};
  assign bl_word = {COND_AL, 4'hB, {(IMM_W-BR_W){br_off[BR_W-1]}}, br_off};

  always_comb begin
    word_d  = '0;
    valid_d = 1'b0;
    undef_d = 1'b0;
    pend_d  = pend_q;
    hi_d    = hi_q;
    if (flush) begin
      pend_d = 1'b0;
    end else if (in_valid) begin
      pend_d  = 1'b0;
      valid_d = 1'b1;
      if (!comp_state) begin
        word_d = fetch_word;
      end else if (is_imm) begin
        word_d = imm_word;
      end else if (is_bx) begin
        word_d = bx_word;
      end else if (is_bl && !bl_second) begin
        valid_d = 1'b0;
        pend_d  = 1'b1;
        hi_d    = hw[OFF_W-1:0];
      end else if (is_bl && pend_q) begin
        word_d = bl_word;
      end else begin
        undef_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_word  <= '0;
      out_valid <= 1'b0;
      out_undef <= 1'b0;
      pend_q    <= 1'b0;
      hi_q      <= '0;
    end else begin
      out_word  <= word_d;
      out_valid <= valid_d;
      out_undef <= undef_d;
      pend_q    <= pend_d;
      hi_q      <= hi_d;
    end
  end

  a_r11_flush_kills: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && !pend_q);
  a_r1_native_pass: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !flush && !comp_state |=> out_valid && !out_undef && out_word == $past(fetch_word));
  a_r3_always_cond: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !flush && comp_state |=> !out_valid || out_undef || out_word[31:28] == COND_AL);
  a_r10_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_undef |-> out_valid && out_word == '0);
  a_r7_first_half_silent: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !flush && comp_state && is_bl && !bl_second |=> !out_valid && pend_q);
  a_r9_orphan_second: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !flush && comp_state && is_bl && bl_second && !pend_q |=> out_undef);
endmodule

// File: tb/cx_expander_tb.sv
module cx_expander_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] fetch_word = '0;
  logic        addr_a1 = 1'b0;
  logic        comp_state = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] out_word;
  logic        out_valid, out_undef;
  int          n_checks = 0;
  int          n_errors = 0;

  always #4 clk = ~clk;

  cx_expander u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fetch_word(fetch_word),
    .addr_a1(addr_a1), .comp_state(comp_state), .flush(flush),
    .out_word(out_word), .out_valid(out_valid), .out_undef(out_undef)
  );

  task automatic chk(input string req, input logic [33:0] got, input logic [33:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got valid/undef/word=%b/%b/%h expected %b/%b/%h",
               req, got[33], got[32], got[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic a1, input logic cs, input logic fl);
    @(negedge clk);
    fetch_word = w; addr_a1 = a1; comp_state = cs; flush = fl; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; flush = 1'b0;
  endtask

  function automatic logic [33:0] ok(input logic [31:0] w);
    return {2'b10, w};
  endfunction

  localparam logic [33:0] UNDEF = {2'b11, 32'h0};
  localparam logic [33:0] NONE  = {2'b00, 32'h0};

  task automatic t_reset();
    chk("R12 reset", {out_valid, out_undef, out_word}, NONE);
    issue({16'hFFFF, 16'hFFFF}, 1'b0, 1'b1, 1'b0);
    chk("R12 no pending after reset", {out_valid, out_undef, out_word}, UNDEF);
  endtask

  task automatic t_native();
    issue(32'hF0012380, 1'b1, 1'b0, 1'b0);
    chk("R1 R13 native passthrough", {out_valid, out_undef, out_word}, ok(32'hF0012380));
    issue(32'h47480000, 1'b0, 1'b0, 1'b0);
    chk("R1 native no rewrite", {out_valid, out_undef, out_word}, ok(32'h47480000));
  endtask

  task automatic t_halfsel();
    issue({16'h2380, 16'hFFFF}, 1'b1, 1'b1, 1'b0);
    chk("R2 upper half move", {out_valid, out_undef, out_word}, ok(32'hE3B03080));
    issue({16'h2380, 16'hFFFF}, 1'b0, 1'b1, 1'b0);
    chk("R2 lower half picked", {out_valid, out_undef, out_word}, UNDEF);
  endtask

  task automatic t_imm();
    issue({16'h0000, 16'h2D12}, 1'b0, 1'b1, 1'b0);
    chk("R4 compare", {out_valid, out_undef, out_word}, ok(32'hE3550012));
    issue({16'h37FF, 16'h0000}, 1'b1, 1'b1, 1'b0);
    chk("R4 R5 add r7 imm ff", {out_valid, out_undef, out_word}, ok(32'hE29770FF));
    issue({16'h0000, 16'h3801}, 1'b0, 1'b1, 1'b0);
    chk("R3 R4 subtract", {out_valid, out_undef, out_word}, ok(32'hE2500001));
  endtask

  task automatic t_bx();
    issue({16'h4748, 16'h0000}, 1'b1, 1'b1, 1'b0);
    chk("R6 branch-exchange r9", {out_valid, out_undef, out_word}, ok(32'hE12FFF19));
    issue({16'h0000, 16'h4749}, 1'b0, 1'b1, 1'b0);
    chk("R10 bad exchange low bits", {out_valid, out_undef, out_word}, UNDEF);
  endtask

  task automatic t_bl();
    issue({16'h0000, 16'hF001}, 1'b0, 1'b1, 1'b0);
    chk("R7 first half silent", {out_valid, out_undef, out_word}, NONE);
    issue({16'hFA34, 16'h0000}, 1'b1, 1'b1, 1'b0);
    chk("R8 positive long branch", {out_valid, out_undef, out_word}, ok(32'hEB000A34));
    issue({16'h0000, 16'hF7FF}, 1'b0, 1'b1, 1'b0);
    issue({16'h0000, 16'hFFF0}, 1'b0, 1'b1, 1'b0);
    chk("R8 negative long branch", {out_valid, out_undef, out_word}, ok(32'hEBFFFFF0));
    issue({16'h0000, 16'hFFF0}, 1'b0, 1'b1, 1'b0);
    chk("R9 orphan second half", {out_valid, out_undef, out_word}, UNDEF);
    issue({16'h0000, 16'hF001}, 1'b0, 1'b1, 1'b0);
    issue({16'h0000, 16'h2380}, 1'b0, 1'b1, 1'b0);
    issue({16'h0000, 16'hFA34}, 1'b0, 1'b1, 1'b0);
    chk("R9 intervening op clears pending", {out_valid, out_undef, out_word}, UNDEF);
  endtask

  task automatic t_unsupported();
    issue({16'h0000, 16'h0000}, 1'b0, 1'b1, 1'b0);
    chk("R10 zero halfword", {out_valid, out_undef, out_word}, UNDEF);
    issue({16'hE000, 16'h0000}, 1'b1, 1'b1, 1'b0);
    chk("R10 other encoding", {out_valid, out_undef, out_word}, UNDEF);
  endtask

  task automatic t_flush();
    issue(32'h12345678, 1'b0, 1'b0, 1'b1);
    chk("R11 flush drops input", {out_valid, out_undef, out_word}, NONE);
    issue({16'h0000, 16'hF001}, 1'b0, 1'b1, 1'b0);
    issue(32'h0, 1'b0, 1'b1, 1'b1);
    issue({16'h0000, 16'hFA34}, 1'b0, 1'b1, 1'b0);
    chk("R11 flush discards pending", {out_valid, out_undef, out_word}, UNDEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_native();
    t_halfsel();
    t_imm();
    t_bx();
    t_bl();
    t_unsupported();
    t_flush();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule